// File: doc/BRIEF.md
# Key-enabled configuration window mapper

This block translates I/O port accesses into configuration transactions for a downstream target. Two small registers sit at I/O ports 0x0CF8 to 0x0CFB. The byte at 0x0CF8 is the enable register: its upper nibble acts as a key and bits 3:1 hold a function number. The byte at 0x0CFA is the forward register and holds the target bus number.

While the key nibble is non-zero, the 4 KB I/O window 0xC000 to 0xCFFF is claimed. Port address bits 11:8 select one of 16 devices and bits 7:0 give the register offset. Each claimed access sends exactly one request to the downstream target. The request carries the bus, device, function, dword-aligned offset, byte enables, write data and direction. The I/O access completes once the target answers.

With the key nibble at zero, the window is not claimed. Any address outside the window and the register block is not claimed either. Reads of unclaimed addresses return all ones and writes to them are dropped. Software opens the window by writing the key together with the function number, and closes it by writing 0x00 to 0x0CF8. It detects the block by clearing 0x0CFB, 0x0CF8 and 0x0CFA and then reading zeros back.

Top module: `cfgmap_top`

## Requirements
- R1: After reset the enable and forward registers are 0x00, `cfg_req_o` is low and `io_ack_o` is low.
- R2: A byte write to 0x0CF8 stores all 8 bits, and a read of 0x0CF8 returns them. Bit 0 has no effect on any request field. The request function field equals enable bits 3:1.
- R3: A byte write to 0x0CFA stores the bus number, and a read returns it. Writes to 0x0CF9 and 0x0CFB change nothing, and those ports always read 0x00.
- R4: The register block is one dword with byte lanes selected by address bits 1:0. Lane 0 is the enable register and lane 2 is the forward register. A word or dword access reaches every lane it covers.
- R5: When enable bits 7:4 are non-zero, an access to port 0xC000 + device*256 + offset gives exactly one request. That request carries bus = forward register, device = address bits 11:8, offset = address bits 7:2 with bits 1:0 cleared, and write = the direction of the access.
- R6: Size code 0 is a byte, 1 is a word, and 2 or 3 is a dword. The byte enables are the mask 0x1, 0x3 or 0xF shifted left by address bits 1:0, with any bits above bit 3 dropped. Write data, right-justified on the I/O side, is shifted left by 8 times address bits 1:0.
- R7: For a window read, the target's data is shifted right by 8 times address bits 1:0. Bytes beyond the access size are then zeroed.
- R8: When enable bits 7:4 are zero (also after writing 0x00 to 0x0CF8), window accesses send no request. Reads return 0xFFFFFFFF and writes are dropped.
- R9: After 0x00 is written to 0x0CFB, 0x0CF8 and 0x0CFA in that order, both 0x0CF8 and 0x0CFA read 0x00.
- R10: An address outside the register block and outside the window sends no request, and a read of it returns 0xFFFFFFFF.
- R11: `io_ack_o` is a one-cycle pulse. A local access acknowledges in the cycle after it is accepted. A window access acknowledges in the cycle after the cycle in which `cfg_req_o` and `cfg_ack_i` are both high.
- R12: `cfg_req_o` stays high with every request field stable until `cfg_ack_i`, and it is low in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | One-cycle access strobe, taken while idle |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 16 | I/O port address |
| io_size_i | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_wdata_i | input | 32 | Right-justified write data |
| io_ack_o | output | 1 | Access completion pulse |
| io_rdata_o | output | 32 | Right-justified read data, valid with `io_ack_o` |
| cfg_req_o | output | 1 | Downstream request, held until acknowledged |
| cfg_we_o | output | 1 | Downstream direction |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_dev_o | output | 4 | Target device number |
| cfg_fn_o | output | 3 | Target function number |
| cfg_off_o | output | 8 | Dword-aligned register offset |
| cfg_be_o | output | 4 | Byte lane enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_ack_i | input | 1 | Downstream completion |
| cfg_rdata_i | input | 32 | Lane-aligned read data from the target |

## Verification
The hardest case to reach is a window access with a sub-dword size at a non-zero lane offset, made while the downstream target holds back its answer. Only then can lane steering, truncated byte enables and field stability under back-pressure all go wrong together. The bench gets there with a responder whose acknowledge latency can be set. It then issues misaligned byte and word writes and offset reads with that latency raised. It also watches each request cycle by cycle for field changes, and checks that the request drops after the handshake.

// File: rtl/cfgmap_pkg.sv
package cfgmap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_REGS = 2'd1,
    HIT_WIN  = 2'd2
  } hit_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cfgmap_decode.sv
module cfgmap_decode
  import cfgmap_pkg::*;
#(
  parameter int unsigned     IO_AW    = 16,
  parameter int unsigned     DEV_W    = 4,
  parameter int unsigned     OFF_W    = 8,
  parameter int unsigned     LANE_AW  = 2,
  parameter logic [IO_AW-1:0] REG_BASE = 16'h0CF8,
  parameter int unsigned     TAG_W    = IO_AW - DEV_W - OFF_W,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'hC
) (
  input  logic [IO_AW-1:0]   addr_i,
  input  logic               win_open_i,
  output hit_e               hit_o,
  output logic [DEV_W-1:0]   dev_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [LANE_AW-1:0] lane_ofs_o
);

  logic reg_hit, win_hit;

  assign reg_hit    = addr_i[IO_AW-1:LANE_AW] == REG_BASE[IO_AW-1:LANE_AW];
  assign win_hit    = win_open_i && (addr_i[IO_AW-1 -: TAG_W] == WIN_TAG);
  assign dev_o      = addr_i[OFF_W +: DEV_W];
  assign off_o      = {addr_i[OFF_W-1:LANE_AW], {LANE_AW{1'b0}}};
  assign lane_ofs_o = addr_i[LANE_AW-1:0];

  always_comb begin
    if (reg_hit)      hit_o = HIT_REGS;
    else if (win_hit) hit_o = HIT_WIN;
    else              hit_o = HIT_NONE;
  end

endmodule

// File: rtl/cfgmap_lanes.sv
module cfgmap_lanes
  import cfgmap_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned LANES   = DW / BYTE_W,
  parameter int unsigned LANE_AW = $clog2(LANES)
) (
  input  logic [LANE_AW-1:0] lane_ofs_i,
  input  logic [1:0]         size_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      lane_rdata_i,
  output logic [LANES-1:0]   be_o,
  output logic [DW-1:0]      lane_wdata_o,
  output logic [DW-1:0]      rdata_o
);

  localparam int unsigned SH_W = LANE_AW + 3;

  logic [LANES-1:0] size_mask;
  logic [SH_W-1:0]  bit_sh;
  logic [DW-1:0]    rd_shifted;

  always_comb begin
    unique case (size_i)
      2'd0:    size_mask = LANES'(1);
      2'd1:    size_mask = LANES'(3);
      default: size_mask = '1;
    endcase
  end

  assign bit_sh       = {lane_ofs_i, 3'b000};
  assign be_o         = size_mask << lane_ofs_i;
  assign lane_wdata_o = wdata_i << bit_sh;
  assign rd_shifted   = lane_rdata_i >> bit_sh;

  for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
    assign rdata_o[BYTE_W*k +: BYTE_W] = size_mask[k] ? rd_shifted[BYTE_W*k +: BYTE_W]
                                                      : '0;
  end

endmodule

// File: rtl/cfgmap_regs.sv
module cfgmap_regs
  import cfgmap_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned FN_W     = 3,
  parameter int unsigned ENA_LANE = 0,
  parameter int unsigned FWD_LANE = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ena_we_i,
  input  logic [BYTE_W-1:0]       ena_wdata_i,
  input  logic                    fwd_we_i,
  input  logic [BYTE_W-1:0]       fwd_wdata_i,
  output logic                    win_open_o,
  output logic [FN_W-1:0]         fn_o,
  output logic [BYTE_W-1:0]       bus_o,
  output logic [BYTE_W*LANES-1:0] lane_rdata_o
);

  logic [BYTE_W-1:0] ena_q, fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= '0;
      fwd_q <= '0;
    end else begin
      if (ena_we_i) ena_q <= ena_wdata_i;
      if (fwd_we_i) fwd_q <= fwd_wdata_i;
    end
  end

  // key nibble opens the window; bit 0 is storage only
  assign win_open_o = |ena_q[BYTE_W-1:BYTE_W/2];
  assign fn_o       = ena_q[FN_W:1];
  assign bus_o      = fwd_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == ENA_LANE) begin : g_ena
      assign lane_rdata_o[BYTE_W*k +: BYTE_W] = ena_q;
    end else if (k == FWD_LANE) begin : g_fwd
      assign lane_rdata_o[BYTE_W*k +: BYTE_W] = fwd_q;
    end else begin : g_zero
      assign lane_rdata_o[BYTE_W*k +: BYTE_W] = '0;
    end
  end

endmodule

// File: rtl/cfgmap_top.sv
module cfgmap_top
  import cfgmap_pkg::*;
#(
  parameter int unsigned      IO_AW    = 16,
  parameter int unsigned      DW       = 32,
  parameter int unsigned      BUS_W    = 8,
  parameter int unsigned      DEV_W    = 4,
  parameter int unsigned      FN_W     = 3,
  parameter int unsigned      OFF_W    = 8,
  parameter logic [IO_AW-1:0] REG_BASE = 16'h0CF8,
  parameter logic [IO_AW-DEV_W-OFF_W-1:0] WIN_TAG = 4'hC,
  localparam int unsigned     LANES    = DW / BYTE_W,
  localparam int unsigned     LANE_AW  = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_req_i,
  input  logic               io_we_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [1:0]         io_size_i,
  input  logic [DW-1:0]      io_wdata_i,
  output logic               io_ack_o,
  output logic [DW-1:0]      io_rdata_o,
  output logic               cfg_req_o,
  output logic               cfg_we_o,
  output logic [BUS_W-1:0]   cfg_bus_o,
  output logic [DEV_W-1:0]   cfg_dev_o,
  output logic [FN_W-1:0]    cfg_fn_o,
  output logic [OFF_W-1:0]   cfg_off_o,
  output logic [LANES-1:0]   cfg_be_o,
  output logic [DW-1:0]      cfg_wdata_o,
  input  logic               cfg_ack_i,
  input  logic [DW-1:0]      cfg_rdata_i
);

  localparam int unsigned ENA_LANE = 0;
  localparam int unsigned FWD_LANE = 2;

  state_e             state_q;
  hit_e               hit;
  logic               idle, accept, reg_wr;
  logic               win_open;
  logic [FN_W-1:0]    reg_fn;
  logic [BYTE_W-1:0]  reg_bus;
  logic [DW-1:0]      reg_lanes;
  logic [DEV_W-1:0]   dec_dev;
  logic [OFF_W-1:0]   dec_off;
  logic [LANE_AW-1:0] dec_ofs, ofs_q, ln_ofs;
  logic [1:0]         size_q, ln_size;
  logic [DW-1:0]      ln_src, ln_wdata, ln_rdata;
  logic [LANES-1:0]   ln_be;
  logic [DW-1:0]      rdata_q;

  assign idle   = state_q == ST_IDLE;
  assign accept = idle && io_req_i;
  assign reg_wr = accept && (hit == HIT_REGS) && io_we_i;

  // lane unit serves the I/O side while idle, the response while busy
  assign ln_ofs  = idle ? dec_ofs   : ofs_q;
  assign ln_size = idle ? io_size_i : size_q;
  assign ln_src  = idle ? reg_lanes : cfg_rdata_i;

  cfgmap_decode #(
    .IO_AW   (IO_AW),
    .DEV_W   (DEV_W),
    .OFF_W   (OFF_W),
    .LANE_AW (LANE_AW),
    .REG_BASE(REG_BASE),
    .WIN_TAG (WIN_TAG)
  ) i_decode (
    .addr_i    (io_addr_i),
    .win_open_i(win_open),
    .hit_o     (hit),
    .dev_o     (dec_dev),
    .off_o     (dec_off),
    .lane_ofs_o(dec_ofs)
  );

  cfgmap_lanes #(
    .DW     (DW),
    .LANES  (LANES),
    .LANE_AW(LANE_AW)
  ) i_lanes (
    .lane_ofs_i  (ln_ofs),
    .size_i      (ln_size),
    .wdata_i     (io_wdata_i),
    .lane_rdata_i(ln_src),
    .be_o        (ln_be),
    .lane_wdata_o(ln_wdata),
    .rdata_o     (ln_rdata)
  );

  cfgmap_regs #(
    .LANES   (LANES),
    .FN_W    (FN_W),
    .ENA_LANE(ENA_LANE),
    .FWD_LANE(FWD_LANE)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ena_we_i    (reg_wr && ln_be[ENA_LANE]),
    .ena_wdata_i (ln_wdata[BYTE_W*ENA_LANE +: BYTE_W]),
    .fwd_we_i    (reg_wr && ln_be[FWD_LANE]),
    .fwd_wdata_i (ln_wdata[BYTE_W*FWD_LANE +: BYTE_W]),
    .win_open_o  (win_open),
    .fn_o        (reg_fn),
    .bus_o       (reg_bus),
    .lane_rdata_o(reg_lanes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      ofs_q       <= '0;
      size_q      <= '0;
      cfg_req_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_bus_o   <= '0;
      cfg_dev_o   <= '0;
      cfg_fn_o    <= '0;
      cfg_off_o   <= '0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit == HIT_WIN) begin
              state_q     <= ST_CFG;
              ofs_q       <= dec_ofs;
              size_q      <= io_size_i;
              cfg_req_o   <= 1'b1;
              cfg_we_o    <= io_we_i;
              cfg_bus_o   <= BUS_W'(reg_bus);
              cfg_dev_o   <= dec_dev;
              cfg_fn_o    <= reg_fn;
              cfg_off_o   <= dec_off;
              cfg_be_o    <= ln_be;
              cfg_wdata_o <= ln_wdata;
            end else begin
              state_q <= ST_RESP;
              rdata_q <= (hit == HIT_REGS) ? ln_rdata : '1;
            end
          end
        end
        ST_CFG: begin
          if (cfg_ack_i) begin
            state_q   <= ST_RESP;
            cfg_req_o <= 1'b0;
            if (!cfg_we_o) rdata_q <= ln_rdata;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ack_o   = state_q == ST_RESP;
  assign io_rdata_o = rdata_q;

endmodule

// File: rtl/cfgmap_checker.sv
module cfgmap_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 4,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned LANES = DW / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_req_i,
  input logic             io_ack_o,
  input logic             cfg_req_o,
  input logic             cfg_we_o,
  input logic [BUS_W-1:0] cfg_bus_o,
  input logic [DEV_W-1:0] cfg_dev_o,
  input logic [FN_W-1:0]  cfg_fn_o,
  input logic [OFF_W-1:0] cfg_off_o,
  input logic [LANES-1:0] cfg_be_o,
  input logic [DW-1:0]    cfg_wdata_o,
  input logic             cfg_ack_i
);

  p_ack_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o);

  p_ack_after_hs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && cfg_ack_i) |=> io_ack_o);

  p_hold_fields_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_ack_i) |=> (cfg_req_o && $stable(cfg_we_o) && $stable(cfg_bus_o)
      && $stable(cfg_dev_o) && $stable(cfg_fn_o) && $stable(cfg_off_o)
      && $stable(cfg_be_o) && $stable(cfg_wdata_o)));

  p_drop_after_hs_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && cfg_ack_i) |=> !cfg_req_o);

  p_req_from_io_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> $past(io_req_i));

  p_be_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_be_o != '0));

  p_no_ack_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> !io_ack_o);

endmodule

bind cfgmap_top cfgmap_checker #(
  .DW   (DW),
  .BUS_W(BUS_W),
  .DEV_W(DEV_W),
  .FN_W (FN_W),
  .OFF_W(OFF_W),
  .LANES(LANES)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_req_i   (io_req_i),
  .io_ack_o   (io_ack_o),
  .cfg_req_o  (cfg_req_o),
  .cfg_we_o   (cfg_we_o),
  .cfg_bus_o  (cfg_bus_o),
  .cfg_dev_o  (cfg_dev_o),
  .cfg_fn_o   (cfg_fn_o),
  .cfg_off_o  (cfg_off_o),
  .cfg_be_o   (cfg_be_o),
  .cfg_wdata_o(cfg_wdata_o),
  .cfg_ack_i  (cfg_ack_i)
);

// File: tb/test_cfgmap_top.sv
module test_cfgmap_top;

  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        exp_req;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0CF8, 2'd0, 32'h0,         32'h0000_0000, 1'b0, 8'd1},  // R1
    '{1'b0, 16'h0CFA, 2'd0, 32'h0,         32'h0000_0000, 1'b0, 8'd1},  // R1
    '{1'b0, 16'hC000, 2'd2, 32'h0,         32'hFFFF_FFFF, 1'b0, 8'd8},  // R8 closed at reset
    '{1'b1, 16'h0CF8, 2'd0, 32'h0000_00F5, 32'h0,         1'b0, 8'd2},  // R2
    '{1'b0, 16'h0CF8, 2'd0, 32'h0,         32'h0000_00F5, 1'b0, 8'd2},  // R2
    '{1'b1, 16'h0CFA, 2'd0, 32'h0000_003C, 32'h0,         1'b0, 8'd3},  // R3
    '{1'b0, 16'h0CFA, 2'd0, 32'h0,         32'h0000_003C, 1'b0, 8'd3},  // R3
    '{1'b1, 16'h0CFB, 2'd0, 32'h0000_00AA, 32'h0,         1'b0, 8'd3},  // R3
    '{1'b0, 16'h0CFB, 2'd0, 32'h0,         32'h0000_0000, 1'b0, 8'd3},  // R3
    '{1'b1, 16'h0CF9, 2'd0, 32'h0000_0055, 32'h0,         1'b0, 8'd3},  // R3
    '{1'b0, 16'h0CF9, 2'd0, 32'h0,         32'h0000_0000, 1'b0, 8'd3},  // R3
    '{1'b0, 16'h0CFA, 2'd1, 32'h0,         32'h0000_003C, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,         32'h003C_00F5, 1'b0, 8'd4},  // R4
    '{1'b1, 16'h0CF8, 2'd2, 32'h0011_00E2, 32'h0,         1'b0, 8'd4},  // R4
    '{1'b0, 16'h0CF8, 2'd0, 32'h0,         32'h0000_00E2, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h0CFA, 2'd0, 32'h0,         32'h0000_0011, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h1234, 2'd0, 32'h0,         32'hFFFF_FFFF, 1'b0, 8'd10}, // R10
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,         32'hFFFF_FFFF, 1'b0, 8'd10}, // R10
    '{1'b1, 16'h8000, 2'd2, 32'h1234_5678, 32'h0,         1'b0, 8'd10}, // R10
    '{1'b0, 16'hC102, 2'd0, 32'h0,         32'h0000_00B2, 1'b1, 8'd7},  // R7
    '{1'b0, 16'hC206, 2'd1, 32'h0,         32'h0000_A1B2, 1'b1, 8'd7},  // R7
    '{1'b0, 16'hC308, 2'd2, 32'h0,         32'hA1B2_C3D4, 1'b1, 8'd7},  // R7
    '{1'b0, 16'hC310, 2'd0, 32'h0,         32'h0000_00D4, 1'b1, 8'd7},  // R7
    '{1'b1, 16'hC40C, 2'd0, 32'h0000_0099, 32'h0,         1'b1, 8'd5}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [3:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [7:0]  cfg_off;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] resp_data = 32'hA1B2_C3D4;

  int checks = 0, errors = 0;
  int nreq = 0, hold_err = 0, lat = 1, wcnt = 0;
  logic [59:0] snap, cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgmap_top i_cfgmap_top (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(io_req), .io_we_i(io_we), .io_addr_i(io_addr), .io_size_i(io_size),
    .io_wdata_i(io_wdata), .io_ack_o(io_ack), .io_rdata_o(io_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev),
    .cfg_fn_o(cfg_fn), .cfg_off_o(cfg_off), .cfg_be_o(cfg_be), .cfg_wdata_o(cfg_wdata),
    .cfg_ack_i(cfg_ack), .cfg_rdata_i(resp_data)
  );

  // fields packed as {we, bus, dev, fn, off, be, wdata}
  wire [59:0] fields = {cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_off, cfg_be, cfg_wdata};

  // downstream responder with settable latency
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_ack) begin
        cfg_ack = 1'b0;
        if (cfg_req) hold_err++;
      end else if (cfg_req) begin
        if (wcnt == 0) snap = fields;
        else if (fields != snap) hold_err++;
        wcnt++;
        if (wcnt >= lat) begin
          cfg_ack = 1'b1;
          cap     = fields;
          nreq++;
          wcnt    = 0;
        end
      end
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic io_acc(input logic we, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    cyc = 1;
    while (!io_ack && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 100) chk("R11 ack timeout", 64'(cyc), 64'd0);
    rd = io_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] rd;
    int cyc;
    io_acc(1'b1, a, sz, wd, rd, cyc);
  endtask

  task automatic rd_chk(input string rq, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
    logic [31:0] rd;
    int cyc;
    io_acc(1'b0, a, sz, 32'h0, rd, cyc);
    chk(rq, 64'(rd), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, n0;

    repeat (3) @(negedge clk);
    chk("R1 cfg_req after reset", 64'(cfg_req), 64'd0);
    chk("R1 io_ack after reset", 64'(io_ack), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg_req idle", 64'(cfg_req), 64'd0);

    for (int i = 0; i < NV; i++) begin
      n0 = nreq;
      io_acc(VECS[i].we, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, cyc);
      if (!VECS[i].we) chk($sformatf("R%0d vec %0d rdata", VECS[i].rq, i), 64'(rd), 64'(VECS[i].exp));
      chk($sformatf("R%0d vec %0d requests", VECS[i].rq, i), 64'(nreq - n0), 64'(VECS[i].exp_req));
    end

    // R5 / R2: field mapping, function from bits 3:1, bit 0 ignored
    wr(16'h0CF8, 2'd0, 32'hF7);
    wr(16'h0CFA, 2'd0, 32'h5A);
    n0 = nreq;
    wr(16'hC7A4, 2'd2, 32'h1234_5678);
    chk("R5 one request", 64'(nreq - n0), 64'd1);
    chk("R5 fields", 64'(cap), 64'({1'b1, 8'h5A, 4'h7, 3'd3, 8'hA4, 4'hF, 32'h1234_5678}));
    wr(16'h0CF8, 2'd0, 32'hF6);
    wr(16'hC7A4, 2'd2, 32'h1234_5678);
    chk("R2 bit0 no effect", 64'(cap), 64'({1'b1, 8'h5A, 4'h7, 3'd3, 8'hA4, 4'hF, 32'h1234_5678}));

    // R6 / R12: sub-dword lanes under back-pressure
    lat = 3;
    wr(16'hC9A7, 2'd0, 32'h0000_00EE);
    chk("R6 byte lane 3", 64'(cap), 64'({1'b1, 8'h5A, 4'h9, 3'd3, 8'hA4, 4'h8, 32'hEE00_0000}));
    wr(16'hC9A2, 2'd1, 32'h0000_BEEF);
    chk("R6 word upper half", 64'(cap), 64'({1'b1, 8'h5A, 4'h9, 3'd3, 8'hA0, 4'hC, 32'hBEEF_0000}));
    wr(16'hC9A3, 2'd1, 32'h0000_BEEF);
    chk("R6 misaligned word truncated", 64'(cap), 64'({1'b1, 8'h5A, 4'h9, 3'd3, 8'hA0, 4'h8, 32'hEF00_0000}));
    io_acc(1'b0, 16'hCF05, 2'd0, 32'h0, rd, cyc);
    chk("R7 byte lane 1 read", 64'(rd), 64'h0000_00C3);
    chk("R6 read direction", 64'(cap[59]), 64'd0);
    chk("R11 window latency", 64'(cyc), 64'(lat + 1));
    @(negedge clk);
    chk("R11 ack pulse width", 64'(io_ack), 64'd0);
    chk("R12 fields stable, req dropped", 64'(hold_err), 64'd0);
    lat = 1;

    // R11: local timing
    io_acc(1'b0, 16'h0CFA, 2'd0, 32'h0, rd, cyc);
    chk("R11 local latency", 64'(cyc), 64'd1);
    @(negedge clk);
    chk("R11 local ack pulse", 64'(io_ack), 64'd0);

    // R8: closing and zero key nibble
    wr(16'h0CF8, 2'd0, 32'h00);
    n0 = nreq;
    wr(16'hC000, 2'd2, 32'hDEAD_BEEF);
    rd_chk("R8 closed read", 16'hC104, 2'd2, 32'hFFFF_FFFF);
    chk("R8 closed no request", 64'(nreq - n0), 64'd0);
    wr(16'h0CF8, 2'd0, 32'h0E);
    rd_chk("R2 enable readback", 16'h0CF8, 2'd0, 32'h0000_000E);
    rd_chk("R8 zero key read", 16'hC500, 2'd0, 32'hFFFF_FFFF);
    chk("R8 zero key no request", 64'(nreq - n0), 64'd0);

    // R9: detection sequence
    wr(16'h0CF8, 2'd0, 32'hF0);
    wr(16'h0CFA, 2'd0, 32'h77);
    wr(16'h0CFB, 2'd0, 32'h00);
    wr(16'h0CF8, 2'd0, 32'h00);
    wr(16'h0CFA, 2'd0, 32'h00);
    rd_chk("R9 enable reads zero", 16'h0CF8, 2'd0, 32'h0);
    rd_chk("R9 forward reads zero", 16'h0CFA, 2'd0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule